// File: doc/BRIEF.md
# I2S frame clock generator

This block produces the serial bit clock and the left/right frame clock of an I2S-style audio link. As clock master it divides the system clock, which is the audio master clock, by a selectable ratio to get the bit clock. It then counts a selectable number of bit clocks per stereo frame to get the frame clock. As clock slave it takes both clocks from an external device, brings them into the system clock domain through a synchroniser, and detects their edges.

In both roles it gives the neighbouring serialiser two single-cycle strobes: one marks where a data bit should be launched and the other where it should be sampled. A third output, a level, says whether the current slot carries the right-channel word. Software sets the ratios, the polarities, the word length and the bit-clock gating through a two-register write port. A global enable lets the clocks run. While either the transmit or the receive path is marked active, the global enable cannot be cleared.

Top module: `i2s_frame_clkgen`

## Requirements
- R1: After reset all outputs are 0, the block is a slave, and every enable is off.
- R2: In master mode the bit clock period is 2 system clocks when field `mdiv` (format bit 6) is 0, and 4 when it is 1. `launch_stb` is high in the first system clock of each bit period and `sample_stb` in the first clock of its second half. The two strobes are never high together.
- R3: In master mode a frame is 32, 64 or 128 bit periods for `fdiv` (format bits 5:4) = 0, 1, or 2/3. `right_slot` is 0 in the first half of the frame and 1 in the second.
- R4: With `binv` (format bit 1) clear, the bit clock is low in the first half of each bit period, so data changes on its falling edge. With `binv` set, the bit clock is inverted and data changes on the rising edge. The idle level of the bit clock equals `binv`.
- R5: `lrclk_out` equals `right_slot` XOR `linv` (format bit 0), so with `linv` clear the left word goes out while the frame clock is low. When the clock is not driven, the output rests at `linv`.
- R6: With `nogate` (format bit 3) set, the bit clock runs in every bit period. When clear, the bit clock rests at its idle level in bit positions, counted within each half frame, at or beyond the word length: 16, 24 or 32 bits for `wl` (format bits 8:7) = 0, 1, 2/3.
- R7: A write to the enable register (address 1) sets `tx_en` from bit 1, `rx_en` from bit 2, and the global enable from bit 0. A request to clear the global enable is ignored while the newly written `tx_en` or `rx_en` is set.
- R8: While the master clocks run, a write to the format register (address 0) takes effect only at the next frame boundary. The clocks finish the current frame with the old ratios and polarities.
- R9: When the master clocks start, the first driven cycle is bit 0 of the left word: `launch_stb` is 1, `right_slot` is 0 and `lrclk_out` equals `linv`.
- R10: In slave mode (format bit 2 clear, global enable on), an edge on `bclk_in` present before system clock edge n produces its strobe in the cycle after edge n+2. `right_slot` follows `lrclk_in` XOR `linv` with the same two-edge delay.
- R11: In slave mode with `binv` clear, `launch_stb` marks falling edges of `bclk_in` and `sample_stb` marks rising ones. With `binv` set, the roles swap.
- R12: `bclk_oe` and `lrclk_oe` are 1 only while the block runs as master with the global enable on. With the global enable off, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, equal to the audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 format, 1 enables |
| cfg_wdata | input | 9 | Register write data |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| lrclk_out | output | 1 | Generated frame clock |
| bclk_oe | output | 1 | Drive enable for the bit clock pad |
| lrclk_oe | output | 1 | Drive enable for the frame clock pad |
| launch_stb | output | 1 | One-cycle strobe: launch the next data bit |
| sample_stb | output | 1 | One-cycle strobe: sample the current data bit |
| right_slot | output | 1 | High while the right-channel word is in flight |

## Verification
The hardest case to reach is a format write that lands in the middle of a running frame. Any wrong handling shows up only as a single runt bit or a shortened frame at the following boundary. The stimulus aligns itself to the frame counter seen at the ports and writes new ratios, polarities and gating about ten cycles into a frame. Each clock, a behavioural model that keeps the old setting until its own frame count wraps then judges the outputs. Slave edges are driven with irregular spacing, in both polarities, so that the synchroniser delay is checked on both rising and falling edges.

// File: rtl/i2s_ckg_pkg.sv
package i2s_ckg_pkg;

    localparam int FMT_W  = 9;
    localparam int MCNT_W = 2;
    localparam int BCNT_W = 7;

    typedef struct packed {
        logic [1:0] wl;
        logic       mdiv;
        logic [1:0] fdiv;
        logic       nogate;
        logic       master;
        logic       binv;
        logic       linv;
    } ckg_fmt_t;

    function automatic logic [MCNT_W-1:0] mclk_last(input logic sel);
        return sel ? MCNT_W'(3) : MCNT_W'(1);
    endfunction

    function automatic logic [MCNT_W-1:0] mclk_mid(input logic sel);
        return sel ? MCNT_W'(2) : MCNT_W'(1);
    endfunction

    function automatic logic [BCNT_W-1:0] frame_half(input logic [1:0] sel);
        case (sel)
            2'd0:    return BCNT_W'(16);
            2'd1:    return BCNT_W'(32);
            default: return BCNT_W'(64);
        endcase
    endfunction

    function automatic logic [BCNT_W-1:0] word_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return BCNT_W'(16);
            2'd1:    return BCNT_W'(24);
            default: return BCNT_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/ckg_regs.sv
module ckg_regs
    import i2s_ckg_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FMT_W-1:0]  wr_data,
    output ckg_fmt_t          fmt_shadow,
    output logic              gen_en,
    output logic              tx_en,
    output logic              rx_en
);
    localparam logic [ADDR_W-1:0] ADDR_FMT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_EN  = ADDR_W'(1);

    logic path_busy;
    assign path_busy = wr_data[1] | wr_data[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_shadow <= '0;
            gen_en     <= 1'b0;
            tx_en      <= 1'b0;
            rx_en      <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_FMT) begin
                fmt_shadow <= ckg_fmt_t'(wr_data);
            end else if (wr_addr == ADDR_EN) begin
                tx_en  <= wr_data[1];
                rx_en  <= wr_data[2];
                gen_en <= wr_data[0] | (gen_en & path_busy);
            end
        end
    end
endmodule

// File: rtl/ckg_master.sv
module ckg_master
    import i2s_ckg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     gen_en,
    input  ckg_fmt_t fmt_shadow,
    output ckg_fmt_t act_fmt,
    output logic     bclk_q,
    output logic     lrclk_q,
    output logic     oe_q,
    output logic     launch_q,
    output logic     sample_q,
    output logic     right_q
);
    logic [MCNT_W-1:0] mcnt;
    logic [BCNT_W-1:0] bcnt;
    logic              run;
    logic [MCNT_W-1:0] m_last, m_mid;
    logic [BCNT_W-1:0] half, f_last, pos;
    logic              in_right, bit_hi, visible;

    always_comb begin
        run      = gen_en & act_fmt.master;
        m_last   = mclk_last(act_fmt.mdiv);
        m_mid    = mclk_mid(act_fmt.mdiv);
        half     = frame_half(act_fmt.fdiv);
        f_last   = (half << 1) - BCNT_W'(1);
        pos      = bcnt & (half - BCNT_W'(1));
        in_right = (bcnt >= half);
        bit_hi   = (mcnt >= m_mid);
        visible  = act_fmt.nogate | (pos < word_bits(act_fmt.wl));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt     <= '0;
            bcnt     <= '0;
            act_fmt  <= '0;
            bclk_q   <= 1'b0;
            lrclk_q  <= 1'b0;
            oe_q     <= 1'b0;
            launch_q <= 1'b0;
            sample_q <= 1'b0;
            right_q  <= 1'b0;
        end else begin
            oe_q     <= run;
            launch_q <= run & (mcnt == '0);
            sample_q <= run & (mcnt == m_mid);
            right_q  <= run & in_right;
            bclk_q   <= (run & visible) ? (bit_hi ^ act_fmt.binv) : act_fmt.binv;
            lrclk_q  <= run ? (in_right ^ act_fmt.linv) : act_fmt.linv;
            if (!run) begin
                mcnt    <= '0;
                bcnt    <= '0;
                act_fmt <= fmt_shadow;
            end else if (mcnt == m_last) begin
                mcnt <= '0;
                if (bcnt == f_last) begin
                    bcnt    <= '0;
                    act_fmt <= fmt_shadow;
                end else begin
                    bcnt <= bcnt + BCNT_W'(1);
                end
            end else begin
                mcnt <= mcnt + MCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ckg_slave.sv
module ckg_slave
    import i2s_ckg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     gen_en,
    input  ckg_fmt_t act_fmt,
    input  logic     bclk_in,
    input  logic     lrclk_in,
    output logic     launch_q,
    output logic     sample_q,
    output logic     right_q
);
    localparam int TAP = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0] b_sh, l_sh;
    logic en, rise, fall;

    always_comb begin
        en   = gen_en & ~act_fmt.master;
        rise = b_sh[TAP] & ~b_sh[SYNC_STAGES];
        fall = ~b_sh[TAP] & b_sh[SYNC_STAGES];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_sh     <= '0;
            l_sh     <= '0;
            launch_q <= 1'b0;
            sample_q <= 1'b0;
            right_q  <= 1'b0;
        end else begin
            b_sh     <= {b_sh[SYNC_STAGES-1:0], bclk_in};
            l_sh     <= {l_sh[SYNC_STAGES-1:0], lrclk_in};
            launch_q <= en & (act_fmt.binv ? rise : fall);
            sample_q <= en & (act_fmt.binv ? fall : rise);
            right_q  <= en & (l_sh[TAP] ^ act_fmt.linv);
        end
    end
endmodule

// File: rtl/i2s_frame_clkgen.sv
module i2s_frame_clkgen
    import i2s_ckg_pkg::*;
#(
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FMT_W-1:0]  cfg_wdata,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    output logic              bclk_out,
    output logic              lrclk_out,
    output logic              bclk_oe,
    output logic              lrclk_oe,
    output logic              launch_stb,
    output logic              sample_stb,
    output logic              right_slot
);
    ckg_fmt_t fmt_shadow, act_fmt;
    logic gen_en, tx_en, rx_en;
    logic m_oe, m_launch, m_sample, m_right;
    logic s_launch, s_sample, s_right;

    ckg_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .fmt_shadow(fmt_shadow), .gen_en(gen_en),
        .tx_en(tx_en), .rx_en(rx_en)
    );

    ckg_master mst_i (
        .clk(clk), .rst(rst), .gen_en(gen_en), .fmt_shadow(fmt_shadow),
        .act_fmt(act_fmt), .bclk_q(bclk_out), .lrclk_q(lrclk_out),
        .oe_q(m_oe), .launch_q(m_launch), .sample_q(m_sample), .right_q(m_right)
    );

    ckg_slave #(.SYNC_STAGES(SYNC_STAGES)) slv_i (
        .clk(clk), .rst(rst), .gen_en(gen_en), .act_fmt(act_fmt),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .launch_q(s_launch), .sample_q(s_sample), .right_q(s_right)
    );

    assign bclk_oe    = m_oe;
    assign lrclk_oe   = m_oe;
    assign launch_stb = m_launch | s_launch;
    assign sample_stb = m_sample | s_sample;
    assign right_slot = m_right | s_right;
endmodule

// File: rtl/ckg_checker.sv
module ckg_checker (
    input logic clk,
    input logic rst,
    input logic bclk_out,
    input logic lrclk_out,
    input logic bclk_oe,
    input logic launch_stb,
    input logic sample_stb,
    input logic gen_en,
    input logic tx_en,
    input logic rx_en,
    input logic act_binv,
    input logic act_nogate
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && sample_stb)); // R2

    AST_LAUNCH_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (launch_stb && bclk_oe) |-> (bclk_out == act_binv)); // R4

    AST_SAMPLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && bclk_oe && act_nogate) |-> (bclk_out != act_binv)); // R4

    AST_LR_AT_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (bclk_oe && $past(bclk_oe) && (lrclk_out != $past(lrclk_out))) |-> launch_stb); // R8

    AST_GEN_LOCK: assert property (@(posedge clk) disable iff (rst)
        $fell(gen_en) |-> (!tx_en && !rx_en)); // R7

    AST_STB_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (launch_stb || sample_stb) |-> $past(gen_en)); // R12
endmodule

bind i2s_frame_clkgen ckg_checker chk_i (
    .clk(clk), .rst(rst), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
    .bclk_oe(bclk_oe), .launch_stb(launch_stb), .sample_stb(sample_stb),
    .gen_en(gen_en), .tx_en(tx_en), .rx_en(rx_en),
    .act_binv(act_fmt.binv), .act_nogate(act_fmt.nogate)
);

// File: tb/i2s_frame_clkgen_tb_top.sv
module i2s_frame_clkgen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [0:0] cfg_addr = '0;
    logic [8:0] cfg_wdata = '0;
    logic bclk_in = 1'b0;
    logic lrclk_in = 1'b0;
    logic bclk_out, lrclk_out, bclk_oe, lrclk_oe, launch_stb, sample_stb, right_slot;

    int nchk = 0;
    int nerr = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    i2s_frame_clkgen dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .bclk_out(bclk_out), .lrclk_out(lrclk_out), .bclk_oe(bclk_oe),
        .lrclk_oe(lrclk_oe), .launch_stb(launch_stb), .sample_stb(sample_stb),
        .right_slot(right_slot)
    );

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int   sh_fmt, a_fmt, t;
    bit   m_gen, m_tx, m_rx;
    logic bq[$];
    logic lq[$];
    logic e_bclk, e_lr, e_oe, e_launch, e_sample, e_right;

    function automatic int per_bit(int f);  return ((f >> 6) & 1) ? 4 : 2; endfunction
    function automatic int per_frame(int f);
        case ((f >> 4) & 3) 0: return 32; 1: return 64; default: return 128; endcase
    endfunction
    function automatic int wlen(int f);
        case ((f >> 7) & 3) 0: return 16; 1: return 24; default: return 32; endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            sh_fmt = 0; a_fmt = 0; t = 0; m_gen = 0; m_tx = 0; m_rx = 0;
            bq = '{1'b0, 1'b0, 1'b0};
            lq = '{1'b0, 1'b0, 1'b0};
            e_bclk <= 0; e_lr <= 0; e_oe <= 0; e_launch <= 0; e_sample <= 0; e_right <= 0;
        end else begin
            int  mp, fp, bitn, sub, pos;
            bit  run, sl, binv, linv, rgt, vis, hi;
            mp   = per_bit(a_fmt);
            fp   = per_frame(a_fmt);
            binv = a_fmt[1];
            linv = a_fmt[0];
            run  = m_gen && a_fmt[2];
            sl   = m_gen && !a_fmt[2];
            bitn = t / mp;
            sub  = t % mp;
            pos  = bitn % (fp / 2);
            rgt  = bitn >= fp / 2;
            vis  = a_fmt[3] || (pos < wlen(a_fmt));
            hi   = sub >= mp / 2;
            if (run) begin
                e_oe <= 1; e_launch <= (sub == 0); e_sample <= (sub == mp / 2);
                e_right <= rgt; e_lr <= rgt ^ linv; e_bclk <= vis ? (hi ^ binv) : binv;
            end else begin
                e_oe <= 0; e_lr <= linv; e_bclk <= binv;
                e_launch <= sl && (binv ? (!bq[2] && bq[1]) : (bq[2] && !bq[1]));
                e_sample <= sl && (binv ? (bq[2] && !bq[1]) : (!bq[2] && bq[1]));
                e_right  <= sl && (lq[1] ^ linv);
            end
            if (!run) begin
                t = 0; a_fmt = sh_fmt;
            end else begin
                t++;
                if (t == mp * fp) begin t = 0; a_fmt = sh_fmt; end
            end
            if (cfg_we) begin
                if (cfg_addr == 0) sh_fmt = int'(cfg_wdata);
                else begin
                    m_gen = cfg_wdata[0] || (m_gen && (cfg_wdata[1] || cfg_wdata[2]));
                    m_tx = cfg_wdata[1]; m_rx = cfg_wdata[2];
                end
            end
            bq.push_front(bclk_in); void'(bq.pop_back());
            lq.push_front(lrclk_in); void'(lq.pop_back());
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 R4 R6 R8", "bclk_out", int'(bclk_out), int'(e_bclk));
            chk("R3 R5 R8", "lrclk_out", int'(lrclk_out), int'(e_lr));
            chk("R12", "bclk_oe", int'(bclk_oe), int'(e_oe));
            chk("R12", "lrclk_oe", int'(lrclk_oe), int'(e_oe));
            chk("R2 R10 R11", "launch_stb", int'(launch_stb), int'(e_launch));
            chk("R2 R10 R11", "sample_stb", int'(sample_stb), int'(e_sample));
            chk("R3 R11", "right_slot", int'(right_slot), int'(e_right));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 1'(a); cfg_wdata = 9'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic slave_drive(input int n, input int bper, input int lper);
        int bc = 0, lc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bc++; lc++;
            if (bc >= bper + (i % 2)) begin bc = 0; bclk_in = ~bclk_in; end
            if (lc >= lper) begin lc = 0; lrclk_in = ~lrclk_in; end
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R1 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp_on = 1;
        // R1: reset state
        chk("R1", "idle outputs",
            int'({bclk_out, lrclk_out, bclk_oe, lrclk_oe, launch_stb, sample_stb, right_slot}), 0);

        // master, mdiv=2, 32 bits/frame, ungated, word 16
        wr(0, 9'b00_0_00_1_1_0_0);
        wr(1, 3'b011);
        while (!bclk_oe) @(negedge clk);
        // R9: defined start phase
        chk("R9", "first launch", int'(launch_stb), 1);
        chk("R9", "first right_slot", int'(right_slot), 0);
        chk("R9", "first lrclk", int'(lrclk_out), 0);
        idle(64 * 2 + 9);

        // R8: mid-frame change; old ratio 2 must persist for now
        wr(0, 9'b01_1_01_0_1_1_1);
        prev = int'(bclk_out);
        @(negedge clk);
        chk("R8", "old ratio toggle 1", int'(bclk_out), 1 - prev);
        prev = int'(bclk_out);
        @(negedge clk);
        chk("R8", "old ratio toggle 2", int'(bclk_out), 1 - prev);
        idle(4 * 512);

        // 128 bits/frame via code 3, word 32, gated, ratio 2
        wr(0, 9'b11_0_11_0_1_0_0);
        idle(3 * 256 + 40);

        // R7: clear of global enable refused while transmit is on
        wr(1, 3'b010);
        idle(4);
        chk("R7", "gen held by tx", int'(bclk_oe), 1);
        wr(1, 3'b000);
        idle(4);
        chk("R7", "gen cleared", int'(bclk_oe), 0);

        // slave mode, both polarities
        wr(0, 9'b00_0_00_0_0_0_0);
        wr(1, 3'b101);
        slave_drive(300, 3, 40);
        wr(0, 9'b00_0_00_0_0_1_1);
        slave_drive(300, 2, 33);
        wr(1, 3'b000);
        slave_drive(40, 2, 7);
        chk("R12", "no strobes when disabled", int'(launch_stb | sample_stb), 0);

        idle(4);
        summary();
        $finish;
    end
endmodule